// File: doc/BRIEF.md
# Chip-Select Timing and Wait-State Controller

This block drives one chip-select line of an external bus controller and paces the internal transfer acknowledge for every beat of a transfer. A 32-bit timing word, written and read through a simple register port, holds the fields that shape each transfer. These are a setup delay between the address-valid strobe and chip-select, a primary wait count, a secondary wait count, and an enable that selects the secondary count for the later beats of a burst.

The bus controller raises `addr_vld` for one cycle when the address and attributes become valid. It presents the burst flag and beat count on that same cycle. The strobe works as a valid signal and `ready` as its ready. A strobe is taken only in a cycle where `ready` is high. A strobe while `ready` is low is dropped, not held, so the controller must keep it back until `ready` returns. After the setup delay, chip-select rises. It stays high while the per-beat wait counts run. It falls one clock after the acknowledge of the last beat.

A parameter picks the reset profile. The boot profile comes out of reset with the longest setup and the longest primary wait, so slow boot memory can be read before software writes the register. The standard profile resets to an all-zero word.

Top module: `cs_timing_ctrl`

## Requirements
- R1: After reset the timing word reads 0x003F_FC00 when `BOOT_PROFILE`=1 and 0x0000_0000 when `BOOT_PROFILE`=0. After reset `chip_sel` and `xfer_ack` are low and `ready` is high.
- R2: Bits 25:24, 22, 9 and 3:0 are reserved. They always read 0 and ignore writes, so writing all ones reads back 0xFCBF_FDF0.
- R3: The 2-bit setup field (bits 21:20) holds a value S. `chip_sel` rises at rising edge S+1 counted from the edge that samples `addr_vld`, which is the first edge after the strobe is asserted. Values 0, 1, 2 and 3 give the first, second, third and fourth edge.
- R4: The 6-bit primary wait field (bits 15:10) holds a value W. The first beat's `xfer_ack` is high in the cycle W clocks after the first cycle with `chip_sel` high, so W=0 acknowledges in that first cycle.
- R5: When the secondary enable (bit 23) is 1, each burst beat after the first is acknowledged V+1 cycles after the previous acknowledge, where V is the 6-bit secondary field (bits 31:26).
- R6: When the secondary enable is 0, every later burst beat is acknowledged W+1 cycles after the previous acknowledge.
- R7: When `xfer_burst` is 1 the transfer has `xfer_beats`+1 beats. When it is 0 the transfer has exactly one beat, whatever `xfer_beats` holds.
- R8: `chip_sel` stays high without a gap until the last beat's acknowledge and is low in the next cycle.
- R9: `ready` is low from the cycle after a strobe is accepted until the transfer ends. A strobe in that window starts no transfer.
- R10: The timing fields are captured when the strobe is accepted. A register write during a transfer does not change that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the timing word |
| cfg_wdata | input | 32 | Write data for the timing word |
| cfg_rdata | output | 32 | Current timing word |
| addr_vld | input | 1 | Address-valid strobe, acts as the transfer valid |
| xfer_burst | input | 1 | Burst flag, sampled with the strobe |
| xfer_beats | input | BEAT_W | Beats minus one, sampled with the strobe |
| ready | output | 1 | High when a strobe will be accepted |
| chip_sel | output | 1 | Chip-select, active high |
| xfer_ack | output | 1 | Internal transfer acknowledge, one cycle per beat |

## Verification
Every result is due at a fixed number of clocks after the edge that samples the strobe. Call that edge t0. Chip-select rises after edge t0+S. The first acknowledge comes after edge t0+S+W. Each later beat adds V+1 or W+1 clocks, and chip-select falls one edge after the last acknowledge. The driver works out these edge numbers when it issues each strobe and queues them. A monitor counts rising edges and samples the outputs at the falling edge. It matches each chip-select rise, acknowledge and chip-select fall against the head of its queue, and any event with no queued entry counts as a failure. Register reads are combinational and are sampled on the falling edge after the write cycle.

// File: rtl/cs_timing_pkg.sv
package cs_timing_pkg;
  localparam int CFG_W   = 32;
  localparam int WAIT_W  = 6;
  localparam int SETUP_W = 2;

  localparam int SWS_LSB  = 26;
  localparam int SEN_BIT  = 23;
  localparam int SET_LSB  = 20;
  localparam int PWS_LSB  = 10;

  localparam logic [CFG_W-1:0] CFG_WMASK    = 32'hFCBF_FDF0;
  localparam logic [CFG_W-1:0] CFG_BOOT_RST = 32'h003F_FC00;
  localparam logic [CFG_W-1:0] CFG_STD_RST  = 32'h0000_0000;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2
  } cs_state_e;

  typedef struct packed {
    logic [WAIT_W-1:0]  sws;
    logic               sws_en;
    logic [SETUP_W-1:0] setup;
    logic [WAIT_W-1:0]  pws;
  } cs_timing_t;

  typedef struct packed {
    logic [WAIT_W-1:0] sws;
    logic              sws_en;
    logic [WAIT_W-1:0] pws;
  } cs_beat_t;

  function automatic cs_timing_t decode_cfg(input logic [CFG_W-1:0] w);
    cs_timing_t t;
    t.sws    = w[SWS_LSB +: WAIT_W];
    t.sws_en = w[SEN_BIT];
    t.setup  = w[SET_LSB +: SETUP_W];
    t.pws    = w[PWS_LSB +: WAIT_W];
    return t;
  endfunction
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg
  import cs_timing_pkg::*;
#(
  parameter bit BOOT_PROFILE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output cs_timing_t       timing
);
  localparam logic [CFG_W-1:0] RST_VAL = BOOT_PROFILE ? CFG_BOOT_RST : CFG_STD_RST;

  logic [CFG_W-1:0] word_q;

  for (genvar b = 0; b < CFG_W; b++) begin : g_bit
    if (CFG_WMASK[b]) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  word_q[b] <= RST_VAL[b];
        else if (we) word_q[b] <= wdata[b];
      end
    end else begin : g_rsvd
      assign word_q[b] = 1'b0;
    end
  end

  assign rdata  = word_q;
  assign timing = decode_cfg(word_q);

  p_reserved_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~CFG_WMASK) == '0);
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata == ($past(wdata) & CFG_WMASK));
endmodule

// File: rtl/cs_wait_cnt.sv
module cs_wait_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/cs_seq.sv
module cs_seq
  import cs_timing_pkg::*;
#(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_vld,
  input  logic              burst,
  input  logic [BEAT_W-1:0] beats,
  input  cs_timing_t        cfg,
  input  logic              wait_zero,
  output logic              wait_load,
  output logic [WAIT_W-1:0] wait_val,
  output logic              chip_sel,
  output logic              ack,
  output logic              ready
);
  cs_state_e          state_q;
  cs_beat_t           snap_q;
  logic [SETUP_W-1:0] setup_q;
  logic [BEAT_W-1:0]  left_q;
  logic               accept;

  assign accept = (state_q == ST_IDLE) && addr_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      snap_q  <= '0;
      setup_q <= '0;
      left_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (addr_vld) begin
          snap_q.sws    <= cfg.sws;
          snap_q.sws_en <= cfg.sws_en;
          snap_q.pws    <= cfg.pws;
          left_q        <= burst ? beats : '0;
          setup_q       <= cfg.setup;
          state_q       <= (cfg.setup == '0) ? ST_ACTIVE : ST_SETUP;
        end
        ST_SETUP: begin
          if (setup_q == SETUP_W'(1)) state_q <= ST_ACTIVE;
          else                        setup_q <= setup_q - 1'b1;
        end
        ST_ACTIVE: if (wait_zero) begin
          if (left_q == '0) state_q <= ST_IDLE;
          else              left_q  <= left_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wait_load = 1'b0;
    wait_val  = snap_q.pws;
    if (accept && cfg.setup == '0) begin
      wait_load = 1'b1;
      wait_val  = cfg.pws;
    end else if (state_q == ST_SETUP && setup_q == SETUP_W'(1)) begin
      wait_load = 1'b1;
      wait_val  = snap_q.pws;
    end else if (state_q == ST_ACTIVE && wait_zero && left_q != '0) begin
      wait_load = 1'b1;
      wait_val  = snap_q.sws_en ? snap_q.sws : snap_q.pws;
    end
  end

  assign chip_sel = (state_q == ST_ACTIVE);
  assign ack      = chip_sel && wait_zero;
  assign ready    = (state_q == ST_IDLE);

  p_setup_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg.setup != '0) |=> !chip_sel && !ready);
  p_setup_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg.setup == '0) |=> chip_sel);
  p_cs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && !ack) |=> chip_sel);
  p_cs_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && left_q == '0) |=> !chip_sel && ready);
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !ack) |=> !ready);
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(snap_q));
endmodule

// File: rtl/cs_timing_ctrl.sv
module cs_timing_ctrl
  import cs_timing_pkg::*;
#(
  parameter bit BOOT_PROFILE = 1'b1,
  parameter int BEAT_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              addr_vld,
  input  logic              xfer_burst,
  input  logic [BEAT_W-1:0] xfer_beats,
  output logic              ready,
  output logic              chip_sel,
  output logic              xfer_ack
);
  cs_timing_t        timing;
  logic              wait_load;
  logic [WAIT_W-1:0] wait_val;
  logic              wait_zero;

  cs_cfg_reg #(.BOOT_PROFILE(BOOT_PROFILE)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .timing (timing)
  );

  cs_seq #(.BEAT_W(BEAT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_vld  (addr_vld),
    .burst     (xfer_burst),
    .beats     (xfer_beats),
    .cfg       (timing),
    .wait_zero (wait_zero),
    .wait_load (wait_load),
    .wait_val  (wait_val),
    .chip_sel  (chip_sel),
    .ack       (xfer_ack),
    .ready     (ready)
  );

  cs_wait_cnt #(.CNT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wait_load),
    .load_val (wait_val),
    .zero     (wait_zero)
  );
endmodule

// File: tb/cs_timing_ctrl_bench.sv
module cs_timing_ctrl_bench;
  typedef struct {
    int    cyc;
    string tag;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        addr_vld = 1'b0;
  logic        xfer_burst = 1'b0;
  logic [2:0]  xfer_beats = '0;
  logic        ready, chip_sel, xfer_ack;

  logic        s_we = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [31:0] s_rdata;
  logic        s_ready, s_cs, s_ack;

  int n_chk = 0, n_err = 0, cyc = 0;
  ev_t q_rise[$], q_ack[$], q_fall[$];
  bit  mon_on = 1'b0, cs_prev = 1'b0;
  int  cur_set = 3, cur_pws = 63, cur_sws = 0;
  bit  cur_en = 1'b0;

  cs_timing_ctrl #(.BOOT_PROFILE(1'b1), .BEAT_W(3)) u_cs_timing_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .addr_vld(addr_vld), .xfer_burst(xfer_burst),
    .xfer_beats(xfer_beats), .ready(ready), .chip_sel(chip_sel), .xfer_ack(xfer_ack)
  );

  cs_timing_ctrl #(.BOOT_PROFILE(1'b0), .BEAT_W(3)) u_cs_timing_ctrl_std (
    .clk(clk), .rst_n(rst_n), .cfg_we(s_we), .cfg_wdata(s_wdata),
    .cfg_rdata(s_rdata), .addr_vld(1'b0), .xfer_burst(1'b0),
    .xfer_beats(3'd0), .ready(s_ready), .chip_sel(s_cs), .xfer_ack(s_ack)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pop_check(ref ev_t q[$], input string what);
    ev_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R9", {"unexpected ", what}, cyc, -1);
    end else begin
      e = q.pop_front();
      chk(cyc == e.cyc, e.tag, what, cyc, e.cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (chip_sel && !cs_prev) pop_check(q_rise, "cs rise cycle");
      if (!chip_sel && cs_prev) pop_check(q_fall, "cs fall cycle");
      if (xfer_ack) begin
        chk(chip_sel, "R8", "ack without chip_sel", chip_sel, 1);
        pop_check(q_ack, "ack cycle");
      end
    end
    cs_prev = chip_sel;
  end

  function automatic logic [31:0] mk(input int sws, input bit en, input int set, input int pws);
    return (32'(sws) << 26) | (32'(en) << 23) | (32'(set) << 20) | (32'(pws) << 10);
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_sws = int'(v[31:26]); cur_en = v[23]; cur_set = int'(v[21:20]); cur_pws = int'(v[15:10]);
  endtask

  task automatic s_wr(input logic [31:0] v);
    @(negedge clk);
    s_we = 1'b1; s_wdata = v;
    @(negedge clk);
    s_we = 1'b0;
  endtask

  task automatic start_xfer(input bit burst, input int beats);
    int t0, a, n;
    ev_t e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    t0 = cyc + 1;
    e.cyc = t0 + cur_set; e.tag = "R3"; q_rise.push_back(e);
    a = t0 + cur_set + cur_pws;
    e.cyc = a; e.tag = (burst || beats == 0) ? "R4" : "R7"; q_ack.push_back(e);
    n = burst ? beats + 1 : 1;
    for (int i = 1; i < n; i++) begin
      a += (cur_en ? cur_sws : cur_pws) + 1;
      e.cyc = a; e.tag = cur_en ? "R5" : "R6"; q_ack.push_back(e);
    end
    e.cyc = a + 1; e.tag = "R8"; q_fall.push_back(e);
    addr_vld = 1'b1; xfer_burst = burst; xfer_beats = 3'(beats);
    @(negedge clk);
    addr_vld = 1'b0; xfer_burst = 1'b0; xfer_beats = '0;
  endtask

  task automatic wait_done();
    while (q_rise.size() != 0 || q_ack.size() != 0 || q_fall.size() != 0 || !ready)
      @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", cyc, 20000);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values for both profiles
    chk(cfg_rdata == 32'h003F_FC00, "R1", "boot reset word", cfg_rdata, 32'h003F_FC00);
    chk(s_rdata == 32'h0, "R1", "std reset word", s_rdata, 0);
    chk(!chip_sel && !xfer_ack && ready, "R1", "boot idle outputs", {chip_sel, xfer_ack, ready}, 3'b001);
    chk(!s_cs && !s_ack && s_ready, "R1", "std idle outputs", {s_cs, s_ack, s_ready}, 3'b001);
    mon_on = 1'b1;

    // R3 R4: reset profile timing (setup 3, wait 63)
    start_xfer(1'b0, 0);
    wait_done();

    // R2 reserved bits
    s_wr(32'hFFFF_FFFF);
    @(negedge clk);
    chk(s_rdata == 32'hFCBF_FDF0, "R2", "all-ones readback", s_rdata, 32'hFCBF_FDF0);
    s_wr(32'h0340_020F);
    @(negedge clk);
    chk(s_rdata == 32'h0, "R2", "reserved-only write", s_rdata, 0);

    // R3 R4: zero setup, zero wait
    wr(mk(0, 1'b0, 0, 0));
    start_xfer(1'b0, 0);
    wait_done();

    // R3 R5: setup 1, burst of 4 with secondary wait 1
    wr(mk(1, 1'b1, 1, 2));
    start_xfer(1'b1, 3);
    wait_done();

    // R3 R6: setup 2, burst of 3, secondary disabled
    wr(mk(5, 1'b0, 2, 3));
    start_xfer(1'b1, 2);
    wait_done();

    // R5: secondary wait zero, back-to-back beats
    wr(mk(0, 1'b1, 3, 1));
    start_xfer(1'b1, 7);
    wait_done();

    // R7: non-burst ignores beat count
    wr(mk(2, 1'b1, 0, 2));
    start_xfer(1'b0, 5);
    wait_done();

    // R9: strobe during transfer is dropped
    wr(mk(0, 1'b0, 1, 5));
    start_xfer(1'b0, 0);
    chk(!ready, "R9", "ready while busy", ready, 0);
    addr_vld = 1'b1;
    @(negedge clk);
    addr_vld = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(ready && !chip_sel, "R9", "idle after dropped strobe", {ready, chip_sel}, 2'b10);

    // R10: write during transfer keeps captured timing
    wr(mk(3, 1'b1, 3, 4));
    start_xfer(1'b1, 1);
    wr(mk(0, 1'b0, 0, 0));
    wait_done();
    chk(cfg_rdata == mk(0, 1'b0, 0, 0), "R10", "new word visible", cfg_rdata, mk(0, 1'b0, 0, 0));
    start_xfer(1'b1, 1);
    wait_done();

    chk(q_rise.size() + q_ack.size() + q_fall.size() == 0, "R8", "pending events",
        q_rise.size() + q_ack.size() + q_fall.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule